// File: doc/BRIEF.md
# USB Endpoint-Zero Control and Status Register

This block holds the control and status flags for endpoint 0 of a USB device controller. It sits between a CPU register bus and the USB transaction engine. The CPU reads and writes one 16-bit word. That word is visible only while the endpoint index value is 0 and the address matches the register's slot. The engine reports four kinds of event as single-cycle pulses: a packet arrived, an IN packet was acknowledged, a control transfer ended early, and a STALL was sent. It also reports a fifth pulse when the status stage completes.

Each flag follows its own rule for being set and cleared:
- Two bits of the word are write-one-to-clear strobes with no storage.
- One flag is cleared by writing 0 to it.
- The CPU sets some flags and the hardware clears them.
- The hardware sets other flags.

An early control end also flushes the endpoint FIFO and blocks access to it until the CPU acknowledges the end. A level interrupt summarises every pending event.

Top module: `ep0_ctl_status`

## Requirements
- R1: After reset, all flags are 0. The outputs `stall_req`, `in_ready`, `data_end`, `fifo_flush`, `fifo_block` and `irq` are 0, and a selected read returns 0.
- R2: The word is selected only when `ep_index` is 0 and `cpu_addr` equals `CSR_ADDR`. When it is not selected, `cpu_rdata` is 0 and writes change nothing.
- R3: A selected read returns issue-stall on bit 5, control-end on bit 4, data-end on bit 3, stall-sent on bit 2, in-ready on bit 1 and out-ready on bit 0. Bits 15..6 always read 0, including the strobe bits 7 and 6.
- R4: Out-ready is set by `ev_rx_pkt`. It is cleared by a write with bit 6 set. A write with bit 6 at 0 leaves it unchanged.
- R5: Control-end is set by `ev_ctl_end` and cleared by a write with bit 7 set. While it is set, `fifo_block` is 1. `fifo_flush` pulses for one cycle in the cycle control-end goes from 0 to 1.
- R6: Control-end and out-ready are held independently. Both can be 1 together, and clearing one leaves the other.
- R7: Bit 5 is a plain read/write bit. Its value drives `stall_req`, and writing 0 ends the stall request.
- R8: Stall-sent is set by `ev_stall_sent` and cleared by a write with bit 2 at 0. A write with bit 2 at 1 leaves it unchanged.
- R9: In-ready is set by a write with bit 1 set and cleared by `ev_in_ack`. Writing 0 to bit 1 has no effect. `ev_in_ack` also marks an IN-complete event, which stays pending until the next selected write.
- R10: Data-end is set by a write with bit 3 set, and the same write may also set in-ready or clear out-ready. It is cleared by `ev_status_done`. Writing 0 to bit 3 has no effect.
- R11: `irq` is 1 exactly while control-end, stall-sent, out-ready or a pending IN-complete event is set.
- R12: When a hardware event and a CPU write act on the same flag in the same cycle, the hardware event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ep_index | input | IDX_W | Current endpoint index value |
| cpu_rdata | output | 16 | CPU read data |
| ev_rx_pkt | input | 1 | Setup or OUT packet received pulse |
| ev_in_ack | input | 1 | IN packet acknowledged pulse |
| ev_ctl_end | input | 1 | Control transfer ended early pulse |
| ev_stall_sent | input | 1 | STALL sent after a protocol violation pulse |
| ev_status_done | input | 1 | Status stage completed pulse |
| stall_req | output | 1 | Ask the engine to answer with STALL |
| in_ready | output | 1 | IN packet is loaded |
| data_end | output | 1 | Last data packet is marked |
| fifo_flush | output | 1 | One-cycle FIFO flush |
| fifo_block | output | 1 | Block all FIFO access |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every engine event is a single-cycle pulse. They also assume that `ev_in_ack` and `ev_status_done` arrive only as replies to the engine's own handshakes, and never in the same cycle as a conflicting CPU write to the same flag, except where R12 defines the outcome. The stimulus holds each event input high for exactly one clock and then drops it. CPU writes are also one clock long. Overlaps between an event and a write are created only on purpose, to exercise the R12 priority rule and the combined writes of R10.

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status #(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 4,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  ep_index,
  output logic [15:0]       cpu_rdata,
  input  logic              ev_rx_pkt,
  input  logic              ev_in_ack,
  input  logic              ev_ctl_end,
  input  logic              ev_stall_sent,
  input  logic              ev_status_done,
  output logic              stall_req,
  output logic              in_ready,
  output logic              data_end,
  output logic              fifo_flush,
  output logic              fifo_block,
  output logic              irq
);
  localparam int B_CLR_END = 7, B_CLR_RX = 6, B_STALL = 5, B_END = 4;
  localparam int B_DEND = 3, B_SSENT = 2, B_IRDY = 1, B_ORDY = 0;

  logic sel, wr;
  logic f_ordy, f_end, f_ssent, f_stall, f_irdy, f_dend, f_indone, end_q;

  assign sel = (ep_index == '0) && (cpu_addr == CSR_ADDR);
  assign wr  = sel & cpu_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_ordy   <= 1'b0;
      f_end    <= 1'b0;
      f_ssent  <= 1'b0;
      f_stall  <= 1'b0;
      f_irdy   <= 1'b0;
      f_dend   <= 1'b0;
      f_indone <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      f_ordy   <= ev_rx_pkt     | (f_ordy  & ~(wr &  cpu_wdata[B_CLR_RX]));
      f_end    <= ev_ctl_end    | (f_end   & ~(wr &  cpu_wdata[B_CLR_END]));
      f_ssent  <= ev_stall_sent | (f_ssent & ~(wr & ~cpu_wdata[B_SSENT]));
      f_stall  <= wr ? cpu_wdata[B_STALL] : f_stall;
      f_irdy   <= ~ev_in_ack      & (f_irdy | (wr & cpu_wdata[B_IRDY]));
      f_dend   <= ~ev_status_done & (f_dend | (wr & cpu_wdata[B_DEND]));
      f_indone <= ev_in_ack | (f_indone & ~wr);
      end_q    <= f_end;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (sel) begin
      cpu_rdata[B_STALL] = f_stall;
      cpu_rdata[B_END]   = f_end;
      cpu_rdata[B_DEND]  = f_dend;
      cpu_rdata[B_SSENT] = f_ssent;
      cpu_rdata[B_IRDY]  = f_irdy;
      cpu_rdata[B_ORDY]  = f_ordy;
    end
  end

  assign stall_req  = f_stall;
  assign in_ready   = f_irdy;
  assign data_end   = f_dend;
  assign fifo_block = f_end;
  assign fifo_flush = f_end & ~end_q;
  assign irq        = f_end | f_ssent | f_ordy | f_indone;
endmodule

module ep0_ctl_status_chk #(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 4,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [IDX_W-1:0]  ep_index,
  input logic [15:0]       cpu_rdata,
  input logic              ev_rx_pkt,
  input logic              ev_in_ack,
  input logic              ev_ctl_end,
  input logic              ev_status_done,
  input logic              stall_req,
  input logic              in_ready,
  input logic              data_end,
  input logic              fifo_flush,
  input logic              fifo_block,
  input logic              irq
);
  logic hit;
  assign hit = (ep_index == '0) && (cpu_addr == CSR_ADDR);

  p_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> cpu_rdata == 16'h0);
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[15:6] == 10'h0);
  p_end_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctl_end |=> fifo_block);
  p_flush_in_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> fifo_block);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && hit) |=> $stable(stall_req));
  p_ack_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_ack |=> !in_ready);
  p_status_drops_dend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status_done |=> !data_end);
  p_block_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_block |-> irq);
  p_rx_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> irq);
endmodule

bind ep0_ctl_status ep0_ctl_status_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CSR_ADDR(CSR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .ep_index(ep_index), .cpu_rdata(cpu_rdata), .ev_rx_pkt(ev_rx_pkt),
  .ev_in_ack(ev_in_ack), .ev_ctl_end(ev_ctl_end),
  .ev_status_done(ev_status_done), .stall_req(stall_req),
  .in_ready(in_ready), .data_end(data_end), .fifo_flush(fifo_flush),
  .fifo_block(fifo_block), .irq(irq)
);

// File: tb/ep0_ctl_status_tb.sv
module ep0_ctl_status_tb;
  localparam logic [7:0] A = 8'h10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cpu_addr = A;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_we = 1'b0;
  logic [3:0] ep_index = '0;
  logic ev_rx = 0, ev_ack = 0, ev_end = 0, ev_ss = 0, ev_done = 0;
  logic stall_req, in_ready, data_end, fifo_flush, fifo_block, irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ep0_ctl_status u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ep_index(ep_index), .cpu_rdata(cpu_rdata),
    .ev_rx_pkt(ev_rx), .ev_in_ack(ev_ack), .ev_ctl_end(ev_end),
    .ev_stall_sent(ev_ss), .ev_status_done(ev_done),
    .stall_req(stall_req), .in_ready(in_ready), .data_end(data_end),
    .fifo_flush(fifo_flush), .fifo_block(fifo_block), .irq(irq));

  // {we, wdata, events{rx,ack,end,ss,done}, expected rdata[7:0], expected irq}
  localparam int NV = 21;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 16'h0000, 5'b10000, 8'h01, 1'b1},  // R4 out-ready set
    {1'b1, 16'h0048, 5'b00000, 8'h08, 1'b0},  // R10 clear out-ready + data-end
    {1'b0, 16'h0000, 5'b00001, 8'h00, 1'b0},  // R10 status done
    {1'b1, 16'h000A, 5'b00000, 8'h0A, 1'b0},  // R9 R10 in-ready + data-end
    {1'b0, 16'h0000, 5'b01000, 8'h08, 1'b1},  // R9 ack -> IN complete
    {1'b1, 16'h0004, 5'b00000, 8'h08, 1'b0},  // R9 write acks IN complete
    {1'b0, 16'h0000, 5'b00001, 8'h00, 1'b0},
    {1'b0, 16'h0000, 5'b00010, 8'h04, 1'b1},  // R8 stall-sent set
    {1'b1, 16'h0004, 5'b00000, 8'h04, 1'b1},  // R8 writing 1 keeps
    {1'b1, 16'h0000, 5'b00000, 8'h00, 1'b0},  // R8 writing 0 clears
    {1'b0, 16'h0000, 5'b00100, 8'h10, 1'b1},  // R5 control end
    {1'b0, 16'h0000, 5'b10000, 8'h11, 1'b1},  // R6 both set
    {1'b1, 16'h0084, 5'b00000, 8'h01, 1'b1},  // R6 clear end only
    {1'b1, 16'h0044, 5'b00000, 8'h00, 1'b0},
    {1'b1, 16'h0024, 5'b00000, 8'h20, 1'b0},  // R7 stall on
    {1'b1, 16'h0004, 5'b00000, 8'h00, 1'b0},  // R7 stall off
    {1'b1, 16'h0044, 5'b10000, 8'h01, 1'b1},  // R12 hw set wins
    {1'b1, 16'h0044, 5'b00000, 8'h00, 1'b0},
    {1'b0, 16'h0000, 5'b10000, 8'h01, 1'b1},
    {1'b1, 16'h0004, 5'b00000, 8'h01, 1'b1},  // R4 bit6=0 keeps
    {1'b1, 16'h0044, 5'b00000, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] d, input logic [4:0] ev);
    cpu_we = we; cpu_wdata = d;
    {ev_rx, ev_ack, ev_end, ev_ss, ev_done} = ev;
    @(posedge clk); #1;
    cpu_we = 0; cpu_wdata = '0;
    {ev_rx, ev_ack, ev_end, ev_ss, ev_done} = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", cpu_rdata, 0);
    chk("R1 outs", {stall_req, in_ready, data_end, fifo_flush, fifo_block, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30], VEC[i][29:14], VEC[i][13:9]);
      chk($sformatf("vec%0d R3/R11 rdata", i), cpu_rdata, {8'h00, VEC[i][8:1]});
      chk($sformatf("vec%0d R11 irq", i), irq, VEC[i][0]);
    end

    // R3: reserved and strobe bits read 0; R7 R9 R10 port outputs
    step(1, 16'hFFFF, 0);
    chk("R3 all-ones write", cpu_rdata, 16'h002A);
    chk("R7 stall_req", stall_req, 1);
    chk("R9 in_ready", in_ready, 1);
    chk("R10 data_end", data_end, 1);
    step(0, 0, 5'b01001);
    chk("R9 R10 hw clears", {in_ready, data_end}, 0);
    step(1, 16'h0004, 0);

    // R2: wrong index / address ignored and hidden
    ep_index = 4'd1;
    step(1, 16'h0002, 0);
    chk("R2 hidden read", cpu_rdata, 0);
    chk("R2 write ignored", stall_req, 0);
    ep_index = 4'd0; cpu_addr = 8'h11;
    step(1, 16'h002A, 0);
    chk("R2 bad addr read", cpu_rdata, 0);
    cpu_addr = A; #1;
    chk("R2 state kept", cpu_rdata, 0);

    // R5: flush pulse and block
    cpu_we = 0;
    ev_end = 1; @(posedge clk); #1; ev_end = 0; @(negedge clk);
    chk("R5 flush pulse", fifo_flush, 1);
    chk("R5 block", fifo_block, 1);
    @(negedge clk);
    chk("R5 flush one cycle", fifo_flush, 0);
    step(0, 0, 5'b00100);
    chk("R5 no reflush", fifo_flush, 0);
    // R12: end event with clear in same cycle
    step(1, 16'h0084, 5'b00100);
    chk("R12 end kept", fifo_block, 1);
    step(1, 16'h0084, 0);
    chk("R5 block released", fifo_block, 0);
    chk("R11 irq low", irq, 0);

    // R1: reset again clears
    step(1, 16'h002A, 5'b10010);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 after reset", {cpu_rdata, irq, stall_req}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule